// File: doc/BRIEF.md
# Debounced Multi-Input Wake-Up Controller

This block watches a bank of external wake-up pins and one dedicated force-wake pin. All of them are sampled on a slow clock. Each general pin has its own enable and its own active-level setting. The general pins share one debounce counter. It starts counting as soon as any enabled pin is at its active level, and it fires once the selected hold time has elapsed. The force-wake pin is active low. It has its own enable, its own counter and its own period code.

When a debounce counter fires, the block pulses a wake-up request for one slow-clock cycle and sets a sticky flag for the source that fired. When the general pins fire, the block also records which enabled pins were active at that moment. Software or a power sequencer reads a status word by pulsing a read strobe. The word is valid during the cycle in which the strobe is high. That read clears the flags and the recorded snapshot, unless a new event lands on the same edge.

Top module: `wake_debounce_ctrl`

## Requirements
- R1: After reset, status bits 0, 1 and 3 upward all read 0, and `wakeReq` is low.
- R2: A general pin whose `wkEnable` bit is 0 never causes a wake-up, a flag or a snapshot bit, whatever its level.
- R3: `wkPolarity` bit 1 makes a high level the active level of that pin. Bit 0 makes a low level the active level.
- R4: The debounce code selects how many consecutive slow-clock samples must show activity before the counter fires. Code 0 needs 1 sample, code 1 needs 3, code 2 needs 32, code 3 needs 512, code 4 needs 4096 and code 5 needs 32768. If the inputs turn active just before sample edge k, the flag and `wakeReq` appear after edge k+N, where N is the number of samples.
- R5: Codes 6 and 7 behave as 32768 samples.
- R6: The shared general counter restarts from zero whenever no enabled pin is at its active level, so an interrupted hold does not count toward the period.
- R7: `wakeReq` is high for exactly one cycle per firing. The counter does not fire again while the inputs stay active. It can fire again only after the inputs have gone inactive and turned active once more.
- R8: The force-wake pin is active when low. It is gated by `fwEnable` and timed by `fwDbcCode`, using the same period table as R4 and independently of the general pins.
- R9: Status bit 0 is the sticky force-wake flag and status bit 1 is the sticky general-pin flag. Each stays set until a status read.
- R10: When the general counter fires, status bit 3+i is set to 1 exactly for each pin i that was enabled and active at that moment.
- R11: Status bit 2 shows the level of the force-wake pin as sampled at the most recent slow-clock edge.
- R12: A read pulse clears bits 0, 1 and 3 upward on the next edge. An event firing on that same edge leaves its own flag and snapshot set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wkPins | input | NUM_PINS | Raw general wake-up pins |
| wkEnable | input | NUM_PINS | Per-pin enable |
| wkPolarity | input | NUM_PINS | Per-pin active level (1 = high) |
| wkDbcCode | input | 3 | Debounce period code for the general pins |
| fwPinN | input | 1 | Raw force-wake pin, active low |
| fwEnable | input | 1 | Force-wake enable |
| fwDbcCode | input | 3 | Debounce period code for the force-wake pin |
| statRd | input | 1 | Status read strobe; the read is destructive |
| statData | output | NUM_PINS+3 | Status word: force flag, pin flag, force level, snapshot |
| wakeReq | output | 1 | One-cycle wake-up request pulse |

## Verification
A counter that fails to restart, or that starts one sample late, moves the rise of the flag and of `wakeReq` by one or more cycles. The bench therefore checks the exact cycle, with the flag still clear one cycle before and set on the expected cycle. A stuck "already fired" state shows up either as a missing pulse after the inputs are released and asserted again, or as repeated pulses while they are held. Both are visible within a few cycles. A clear that wins over a set loses a flag only when the read and the event coincide, so that case is driven on purpose and read back on the very next cycle.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

  localparam int CNT_W = 16;

  // status word field positions
  localparam int ST_FORCE = 0;
  localparam int ST_PINS  = 1;
  localparam int ST_LEVEL = 2;
  localparam int ST_SNAP  = 3;

  typedef struct packed {
    logic setForce;
    logic setPins;
    logic clrAll;
  } wkStrobe_t;

  function automatic logic [CNT_W-1:0] dbcLimit(input logic [2:0] code);
    logic [CNT_W-1:0] lim;
    case (code)
      3'd0:    lim = CNT_W'(1);
      3'd1:    lim = CNT_W'(3);
      3'd2:    lim = CNT_W'(32);
      3'd3:    lim = CNT_W'(512);
      3'd4:    lim = CNT_W'(4096);
      default: lim = CNT_W'(32768);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/wkup_debounce.sv
module wkup_debounce
  import wkup_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic [2:0] code,
  output logic       trig
);

  logic [CW-1:0] cnt;
  logic          fired;
  logic [CW-1:0] lastCnt;

  assign lastCnt = CW'(dbcLimit(code)) - CW'(1);
  assign trig    = active && !fired && (cnt >= lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!active) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (trig) begin
      fired <= 1'b1;
    end else if (!fired && cnt != '1) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
  import wkup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinsActive,
  input  logic       forceActive,
  input  logic [2:0] pinsCode,
  input  logic [2:0] forceCode,
  input  logic       statRd,
  output wkStrobe_t  strobe,
  output logic       wakeReq
);

  logic pinsTrig;
  logic forceTrig;

  wkup_debounce #(.CW(CNT_W)) pinsDbc_i (
    .clk   (clk),
    .rstN  (rstN),
    .active(pinsActive),
    .code  (pinsCode),
    .trig  (pinsTrig)
  );

  wkup_debounce #(.CW(CNT_W)) forceDbc_i (
    .clk   (clk),
    .rstN  (rstN),
    .active(forceActive),
    .code  (forceCode),
    .trig  (forceTrig)
  );

  always_comb begin
    strobe.setForce = forceTrig;
    strobe.setPins  = pinsTrig;
    strobe.clrAll   = statRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeReq <= 1'b0;
    else       wakeReq <= pinsTrig || forceTrig;
  end

endmodule

// File: rtl/wkup_datapath.sv
module wkup_datapath
  import wkup_pkg::*;
#(
  parameter int NUM_PINS = 16,
  localparam int STAT_W = NUM_PINS + ST_SNAP
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] wkPins,
  input  logic [NUM_PINS-1:0] wkEnable,
  input  logic [NUM_PINS-1:0] wkPolarity,
  input  logic                fwPinN,
  input  logic                fwEnable,
  input  wkStrobe_t           strobe,
  output logic                pinsActive,
  output logic                forceActive,
  output logic [STAT_W-1:0]   statData
);

  logic [NUM_PINS-1:0] pinSamp;
  logic                fwSamp;
  logic [NUM_PINS-1:0] activeVec;
  logic [NUM_PINS-1:0] snap;
  logic                forceFlag;
  logic                pinsFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSamp <= '0;
      fwSamp  <= 1'b1;
    end else begin
      pinSamp <= wkPins;
      fwSamp  <= fwPinN;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign activeVec[i] = wkEnable[i] && (pinSamp[i] == wkPolarity[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               snap[i] <= 1'b0;
      else if (strobe.setPins) snap[i] <= activeVec[i];
      else if (strobe.clrAll)  snap[i] <= 1'b0;
    end
  end

  assign pinsActive  = |activeVec;
  assign forceActive = fwEnable && !fwSamp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forceFlag <= 1'b0;
      pinsFlag  <= 1'b0;
    end else begin
      if (strobe.setForce)    forceFlag <= 1'b1;
      else if (strobe.clrAll) forceFlag <= 1'b0;
      if (strobe.setPins)     pinsFlag  <= 1'b1;
      else if (strobe.clrAll) pinsFlag  <= 1'b0;
    end
  end

  always_comb begin
    statData                       = '0;
    statData[ST_FORCE]             = forceFlag;
    statData[ST_PINS]              = pinsFlag;
    statData[ST_LEVEL]             = fwSamp;
    statData[ST_SNAP +: NUM_PINS]  = snap;
  end

endmodule

// File: rtl/wake_debounce_ctrl.sv
module wake_debounce_ctrl
  import wkup_pkg::*;
#(
  parameter int NUM_PINS = 16,
  localparam int STAT_W = NUM_PINS + ST_SNAP
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] wkPins,
  input  logic [NUM_PINS-1:0] wkEnable,
  input  logic [NUM_PINS-1:0] wkPolarity,
  input  logic [2:0]          wkDbcCode,
  input  logic                fwPinN,
  input  logic                fwEnable,
  input  logic [2:0]          fwDbcCode,
  input  logic                statRd,
  output logic [STAT_W-1:0]   statData,
  output logic                wakeReq
);

  wkStrobe_t strobe;
  logic      pinsActive;
  logic      forceActive;

  wkup_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinsActive (pinsActive),
    .forceActive(forceActive),
    .pinsCode   (wkDbcCode),
    .forceCode  (fwDbcCode),
    .statRd     (statRd),
    .strobe     (strobe),
    .wakeReq    (wakeReq)
  );

  wkup_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .wkPins     (wkPins),
    .wkEnable   (wkEnable),
    .wkPolarity (wkPolarity),
    .fwPinN     (fwPinN),
    .fwEnable   (fwEnable),
    .strobe     (strobe),
    .pinsActive (pinsActive),
    .forceActive(forceActive),
    .statData   (statData)
  );

endmodule

// File: rtl/wkup_checker.sv
module wkup_checker #(
  parameter int NUM_PINS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] wkEnable,
  input logic                fwEnable,
  input logic                statRd,
  input logic [NUM_PINS+2:0] statData,
  input logic                wakeReq
);

  p_wake_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(fwEnable || (|wkEnable)));

  p_wake_sets_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (statData[0] || statData[1]));

  p_force_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statData[0] && !statRd) |=> statData[0]);

  p_pins_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statData[1] && !statRd) |=> statData[1]);

  p_read_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> ((!statData[0] && !statData[1]) || wakeReq));

  p_flag_rise_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statData[1]) |-> wakeReq);

  p_snap_with_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|statData[NUM_PINS+2:3]) |-> statData[1]);

endmodule

bind wake_debounce_ctrl wkup_checker #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wkEnable(wkEnable),
  .fwEnable(fwEnable),
  .statRd  (statRd),
  .statData(statData),
  .wakeReq (wakeReq)
);

// File: tb/wake_debounce_ctrl_tb_top.sv
module wake_debounce_ctrl_tb_top;

  localparam int NP = 16;
  localparam int SW = NP + 3;

  typedef struct packed {
    logic [15:0] en;
    logic [15:0] pol;
    logic [15:0] pin;
    logic [2:0]  code;
    logic        fire;
    logic [15:0] snap;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0001, 16'h0001, 16'h0001, 3'd0, 1'b1, 16'h0001},
    '{16'h0002, 16'h0000, 16'hFFFD, 3'd1, 1'b1, 16'h0002},
    '{16'h0000, 16'hFFFF, 16'hFFFF, 3'd0, 1'b0, 16'h0000},
    '{16'h00F0, 16'h00F0, 16'h0030, 3'd2, 1'b1, 16'h0030},
    '{16'h8000, 16'h8000, 16'h8000, 3'd3, 1'b1, 16'h8000},
    '{16'h0101, 16'h0100, 16'h0000, 3'd4, 1'b1, 16'h0001},
    '{16'h0004, 16'h0004, 16'h0004, 3'd5, 1'b1, 16'h0004},
    '{16'h0008, 16'h0008, 16'h0008, 3'd6, 1'b1, 16'h0008},
    '{16'h0010, 16'h0000, 16'hFFEF, 3'd7, 1'b1, 16'h0010}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] wkPins = '0;
  logic [NP-1:0] wkEnable = '0;
  logic [NP-1:0] wkPolarity = '0;
  logic [2:0]    wkDbcCode = '0;
  logic          fwPinN = 1'b1;
  logic          fwEnable = 1'b0;
  logic [2:0]    fwDbcCode = '0;
  logic          statRd = 1'b0;
  logic [SW-1:0] statData;
  logic          wakeReq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wake_debounce_ctrl #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .wkPins(wkPins), .wkEnable(wkEnable),
    .wkPolarity(wkPolarity), .wkDbcCode(wkDbcCode), .fwPinN(fwPinN),
    .fwEnable(fwEnable), .fwDbcCode(fwDbcCode), .statRd(statRd),
    .statData(statData), .wakeReq(wakeReq)
  );

  function automatic int expPeriod(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 3;
      3'd2: return 32;
      3'd3: return 512;
      3'd4: return 4096;
      default: return 32768;
    endcase
  endfunction

  function automatic string tagFor(input int i);
    case (i)
      1: return "R3/R4";
      2: return "R2";
      7, 8: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doRead(output logic [SW-1:0] rd);
    @(negedge clk);
    statRd = 1'b1;
    rd = statData;
    @(negedge clk);
    statRd = 1'b0;
  endtask

  task automatic settle();
    logic [SW-1:0] junk;
    wkPins = ~wkPolarity;
    fwPinN = 1'b1;
    repeat (3) @(negedge clk);
    doRead(junk);
  endtask

  task automatic runCase(input int idx);
    vec_t v;
    int n;
    logic [SW-1:0] rd;
    string tg;
    v = VECS[idx];
    tg = tagFor(idx);
    n = expPeriod(v.code);
    @(negedge clk);
    wkEnable = v.en;
    wkPolarity = v.pol;
    wkDbcCode = v.code;
    settle();
    wkPins = v.pin;
    repeat (n) @(negedge clk);
    chkEq(tg, "flag early", 32'(statData[1]), 32'd0);
    @(negedge clk);
    chkEq(tg, "pin flag", 32'(statData[1]), 32'(v.fire));
    chkEq(tg, "wakeReq", 32'(wakeReq), 32'(v.fire));
    chkEq("R10", "snapshot", 32'(statData[SW-1:3]), 32'(v.snap));
    @(negedge clk);
    chkEq("R7", "pulse width", 32'(wakeReq), 32'd0);
    repeat (6) @(negedge clk);
    chkEq("R7", "no retrigger", 32'(wakeReq), 32'd0);
    chkEq("R9", "flag sticky", 32'(statData[1]), 32'(v.fire));
    doRead(rd);
    chkEq("R10", "read snapshot", 32'(rd[SW-1:3]), 32'(v.snap));
    chkEq("R12", "cleared after read", 32'({statData[SW-1:3], statData[1:0]}), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] rd;
    repeat (3) @(negedge clk);
    chkEq("R1", "reset flags", 32'({statData[SW-1:3], statData[1:0]}), 32'd0);
    chkEq("R1", "reset wakeReq", 32'(wakeReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "after release", 32'({statData[SW-1:3], statData[1:0]}), 32'd0);

    for (int i = 0; i < NV; i++) runCase(i);

    // R6: interrupted hold restarts the shared counter (period 3)
    @(negedge clk);
    wkEnable = 16'h0001; wkPolarity = 16'h0001; wkDbcCode = 3'd1;
    settle();
    wkPins = 16'h0001;
    repeat (2) @(negedge clk);
    wkPins = 16'h0000;
    @(negedge clk);
    wkPins = 16'h0001;
    repeat (3) @(negedge clk);
    chkEq("R6", "no fire after gap", 32'(statData[1]), 32'd0);
    @(negedge clk);
    chkEq("R6", "fires after full hold", 32'(wakeReq), 32'd1);
    // R7: release and reassert fires again
    wkPins = 16'h0000;
    @(negedge clk);
    wkPins = 16'h0001;
    repeat (3) @(negedge clk);
    chkEq("R7", "no early refire", 32'(wakeReq), 32'd0);
    @(negedge clk);
    chkEq("R7", "refire after release", 32'(wakeReq), 32'd1);

    // R8/R11: force-wake pin with its own code
    wkEnable = '0; wkDbcCode = 3'd0;
    fwEnable = 1'b1; fwDbcCode = 3'd1;
    settle();
    fwPinN = 1'b0;
    @(negedge clk);
    chkEq("R11", "level low", 32'(statData[2]), 32'd0);
    repeat (2) @(negedge clk);
    chkEq("R8", "force early", 32'(statData[0]), 32'd0);
    @(negedge clk);
    chkEq("R8", "force flag", 32'(statData[0]), 32'd1);
    chkEq("R8", "pin flag untouched", 32'(statData[1]), 32'd0);
    chkEq("R8", "force wakeReq", 32'(wakeReq), 32'd1);
    fwPinN = 1'b1;
    @(negedge clk);
    chkEq("R11", "level high", 32'(statData[2]), 32'd1);
    // R8: disabled force pin is ignored
    fwEnable = 1'b0;
    settle();
    fwPinN = 1'b0;
    repeat (6) @(negedge clk);
    chkEq("R8", "disabled force flag", 32'(statData[0]), 32'd0);
    chkEq("R8", "disabled force wake", 32'(wakeReq), 32'd0);

    // R12: read coinciding with a new pin event
    fwEnable = 1'b1; fwDbcCode = 3'd0;
    settle();
    fwPinN = 1'b0;
    @(negedge clk);
    fwPinN = 1'b1;
    @(negedge clk);
    chkEq("R9", "force flag set", 32'(statData[0]), 32'd1);
    fwEnable = 1'b0;
    wkEnable = 16'h0001; wkPolarity = 16'h0001; wkDbcCode = 3'd0;
    wkPins = 16'h0001;
    @(negedge clk);
    statRd = 1'b1;
    rd = statData;
    @(negedge clk);
    statRd = 1'b0;
    chkEq("R12", "read saw old force", 32'(rd[1:0]), 32'b01);
    chkEq("R12", "new event kept", 32'(statData[1:0]), 32'b10);
    chkEq("R12", "new snapshot kept", 32'(statData[SW-1:3]), 32'h0001);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule